// File: doc/BRIEF.md
# Inter-Processor Doorbell Interrupt Controller

This block lets two processors ring each other. It holds two banks of 32 doorbell bits. The network bank raises an interrupt line toward the network processor, and the application bank raises one toward the application processor. Each bank has a pending word, a mask word, and a group of write-1 command aliases. Software rings a doorbell by writing ones to a bank's trigger alias. The receiver reads raw or masked status, then retires the bits through the status-clear alias or the acknowledge alias.

There are two register ports, one per processor. Each port is a plain address, write-enable, write-data and read-data interface. Both ports reach the full register map. Reads are combinational from the current register state. Writes take effect at the next rising clock edge. Because both ports can write in the same cycle, the block defines how a clear and a set that land on the same bit resolve.

Top module: `ipi_ctrl`

## Requirements
- R1: After synchronous reset both mask words are all ones, both pending words are zero, and both interrupt lines are low.
- R2: Byte offset 0 of a bank is the mask word. It is written and read back directly. A mask bit of 1 disables that doorbell and a 0 enables it. A direct mask write to one bank leaves the other bank's state untouched.
- R3: A 1 written to the mask-set alias (offset 4) sets that mask bit, and a 1 written to the mask-clear alias (offset 8) clears it. A written 0 changes nothing. When set and clear hit the same bit in one cycle, the bit ends up set.
- R4: A 1 written to the trigger alias (offset 0x14) makes that bit pending at the next edge. A written 0 has no effect. The alias reads as zero.
- R5: A 1 written to the status-clear alias (offset 0xC) or to the acknowledge alias (offset 0x10) retires that pending bit. Zeros are ignored.
- R6: A trigger and a clear for the same bit in the same cycle, issued from the two ports, leave the bit pending.
- R7: Raw status (offset 0x1C) returns the pending word and masked status (offset 0x18) returns pending AND NOT mask. Reading either one changes no state.
- R8: Each interrupt line is a register loaded with the OR of its bank's masked status. It therefore follows a change in pending or mask one clock edge later.
- R9: The network bank starts at byte address 0x84 and the application bank at 0xA4, each spanning eight word slots. Write-only aliases and addresses outside both banks read as zero, and writes to unmapped addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nw_addr | input | 8 | Network-side port byte address |
| nw_wr | input | 1 | Network-side port write enable |
| nw_wdata | input | 32 | Network-side port write data |
| nw_rdata | output | 32 | Network-side port read data |
| app_addr | input | 8 | Application-side port byte address |
| app_wr | input | 1 | Application-side port write enable |
| app_wdata | input | 32 | Application-side port write data |
| app_rdata | output | 32 | Application-side port read data |
| irq_nw | output | 1 | Level interrupt to the network processor |
| irq_app | output | 1 | Level interrupt to the application processor |

## Verification
The hardest case to reach is the collision: a clear and a trigger for the same bit arriving in the same cycle. A single port can never produce it. The stimulus therefore drives both ports in one cycle, with status-clear on one and trigger on the other. It then reads raw status to confirm the bit survived while a second, uncontested bit was retired. The same two-port trick drives mask-set against mask-clear. Interrupt timing is sampled in the cycle after the pending update and again one cycle later, which exposes the extra register stage.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    // number of word slots in one bank and its byte span
    localparam int SLOT_CNT  = 8;
    localparam int WIN_BYTES = SLOT_CNT * 4;

    // slot order inside a bank; the position is the address decode
    typedef enum logic [2:0] {
        SL_MASK  = 3'd0,
        SL_MSET  = 3'd1,
        SL_MCLR  = 3'd2,
        SL_SCLR  = 3'd3,
        SL_ACK   = 3'd4,
        SL_TRIG  = 3'd5,
        SL_MSTS  = 3'd6,
        SL_RSTS  = 3'd7
    } slot_e;

    // per-bank write strobes produced by one port
    typedef struct packed {
        logic mask_wr;
        logic mask_set;
        logic mask_clr;
        logic sts_clr;
        logic ack;
        logic trig;
    } wr_strb_t;

    function automatic wr_strb_t slot_strobes(input slot_e s, input logic wr);
        wr_strb_t r;
        r          = '0;
        r.mask_wr  = wr && (s == SL_MASK);
        r.mask_set = wr && (s == SL_MSET);
        r.mask_clr = wr && (s == SL_MCLR);
        r.sts_clr  = wr && (s == SL_SCLR);
        r.ack      = wr && (s == SL_ACK);
        r.trig     = wr && (s == SL_TRIG);
        return r;
    endfunction

endpackage

// File: rtl/ipi_port_decode.sv
module ipi_port_decode
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBANK  = 2,
    parameter logic [NBANK-1:0][ADDR_W-1:0] BASES = '0
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr,
    output logic [NBANK-1:0]           hit,
    output slot_e [NBANK-1:0]          slot,
    output wr_strb_t [NBANK-1:0]       strb
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [ADDR_W-1:0] off;
        assign off     = addr - BASES[b];
        assign hit[b]  = (off < ADDR_W'(WIN_BYTES)) && (off[1:0] == 2'b00);
        assign slot[b] = slot_e'(off[4:2]);
        assign strb[b] = hit[b] ? slot_strobes(slot[b], wr) : '0;
    end

endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
    import ipi_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NPORT  = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  wr_strb_t [NPORT-1:0]           strb,
    input  logic [NPORT-1:0][DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]              mask_q,
    output logic [DATA_W-1:0]              pend_q,
    output logic                           irq_q
);

    logic [DATA_W-1:0] base_mask, mset, mclr, setv, clrv;
    logic [DATA_W-1:0] mask_d, pend_d;

    // gather the strobes of every port; lower port wins a direct mask write
    always_comb begin
        base_mask = mask_q;
        mset      = '0;
        mclr      = '0;
        setv      = '0;
        clrv      = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (strb[p].mask_wr)  base_mask = wdata[p];
            if (strb[p].mask_set) mset = mset | wdata[p];
            if (strb[p].mask_clr) mclr = mclr | wdata[p];
            if (strb[p].trig)     setv = setv | wdata[p];
            if (strb[p].sts_clr || strb[p].ack) clrv = clrv | wdata[p];
        end
        // sets are applied after clears so a coincident set survives
        mask_d = (base_mask & ~mclr) | mset;
        pend_d = (pend_q & ~clrv) | setv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_d;
            pend_q <= pend_d;
            irq_q  <= |(pend_q & ~mask_q);
        end
    end

endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] NW_BASE  = 8'h84,
    parameter logic [ADDR_W-1:0] APP_BASE = 8'hA4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] nw_addr,
    input  logic              nw_wr,
    input  logic [DATA_W-1:0] nw_wdata,
    output logic [DATA_W-1:0] nw_rdata,
    input  logic [ADDR_W-1:0] app_addr,
    input  logic              app_wr,
    input  logic [DATA_W-1:0] app_wdata,
    output logic [DATA_W-1:0] app_rdata,
    output logic              irq_nw,
    output logic              irq_app
);

    localparam int NPORT = 2;
    localparam int NBANK = 2;
    localparam logic [NBANK-1:0][ADDR_W-1:0] BASES = {APP_BASE, NW_BASE};

    logic [NPORT-1:0][ADDR_W-1:0] addr_a;
    logic [NPORT-1:0]             wr_a;
    logic [NPORT-1:0][DATA_W-1:0] wdata_a;
    logic [NPORT-1:0][DATA_W-1:0] rdata_a;

    assign addr_a  = {app_addr, nw_addr};
    assign wr_a    = {app_wr, nw_wr};
    assign wdata_a = {app_wdata, nw_wdata};

    logic     [NBANK-1:0] hit_p  [NPORT];
    slot_e    [NBANK-1:0] slot_p [NPORT];
    wr_strb_t [NBANK-1:0] strb_p [NPORT];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ipi_port_decode #(
            .ADDR_W (ADDR_W),
            .NBANK  (NBANK),
            .BASES  (BASES)
        ) u_dec (
            .addr (addr_a[p]),
            .wr   (wr_a[p]),
            .hit  (hit_p[p]),
            .slot (slot_p[p]),
            .strb (strb_p[p])
        );
    end

    logic [NBANK-1:0][DATA_W-1:0] mask_b;
    logic [NBANK-1:0][DATA_W-1:0] pend_b;
    logic [NBANK-1:0]             irq_b;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        wr_strb_t [NPORT-1:0] bstrb;
        for (genvar p = 0; p < NPORT; p++) begin : g_route
            assign bstrb[p] = strb_p[p][b];
        end
        ipi_bank #(
            .DATA_W (DATA_W),
            .NPORT  (NPORT)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .strb   (bstrb),
            .wdata  (wdata_a),
            .mask_q (mask_b[b]),
            .pend_q (pend_b[b]),
            .irq_q  (irq_b[b])
        );
    end

    // readback: only mask and the two status views return data
    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            rdata_a[p] = '0;
            for (int b = 0; b < NBANK; b++) begin
                if (hit_p[p][b]) begin
                    case (slot_p[p][b])
                        SL_MASK: rdata_a[p] = mask_b[b];
                        SL_MSTS: rdata_a[p] = pend_b[b] & ~mask_b[b];
                        SL_RSTS: rdata_a[p] = pend_b[b];
                        default: rdata_a[p] = '0;
                    endcase
                end
            end
        end
    end

    assign nw_rdata  = rdata_a[0];
    assign app_rdata = rdata_a[1];
    assign irq_nw    = irq_b[0];
    assign irq_app   = irq_b[1];

endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] NW_BASE = 8'h84
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] nw_addr,
    input logic              nw_wr,
    input logic [DATA_W-1:0] nw_wdata,
    input logic [DATA_W-1:0] nw_rdata,
    input logic [ADDR_W-1:0] app_addr,
    input logic              app_wr,
    input logic [DATA_W-1:0] app_wdata,
    input logic              irq_nw,
    input logic [DATA_W-1:0] nw_mask,
    input logic [DATA_W-1:0] nw_pend
);

    localparam logic [ADDR_W-1:0] SCLR_A = NW_BASE + ADDR_W'(12);
    localparam logic [ADDR_W-1:0] ACK_A  = NW_BASE + ADDR_W'(16);
    localparam logic [ADDR_W-1:0] TRIG_A = NW_BASE + ADDR_W'(20);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (nw_mask == '1 && nw_pend == '0 && !irq_nw));

    // R8
    irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
        irq_nw == (|($past(nw_pend & ~nw_mask))));

    // R4
    trig_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (nw_wr && nw_addr == TRIG_A) |=> ((nw_pend & $past(nw_wdata)) == $past(nw_wdata)));

    // R4
    trig_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (nw_addr == TRIG_A) |-> (nw_rdata == '0));

    // R5
    clear_alone_chk: assert property (@(posedge clk) disable iff (rst)
        (nw_wr && (nw_addr == SCLR_A || nw_addr == ACK_A) && !(app_wr && app_addr == TRIG_A))
        |=> ((nw_pend & $past(nw_wdata)) == '0));

    // R6
    coincident_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (nw_wr && nw_addr == SCLR_A && app_wr && app_addr == TRIG_A)
        |=> ((nw_pend & $past(app_wdata)) == $past(app_wdata)));

    // R7
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!nw_wr && !app_wr) |=> ($stable(nw_pend) && $stable(nw_mask)));

endmodule

bind ipi_ctrl ipi_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NW_BASE (NW_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nw_addr   (nw_addr),
    .nw_wr     (nw_wr),
    .nw_wdata  (nw_wdata),
    .nw_rdata  (nw_rdata),
    .app_addr  (app_addr),
    .app_wr    (app_wr),
    .app_wdata (app_wdata),
    .irq_nw    (irq_nw),
    .nw_mask   (mask_b[0]),
    .nw_pend   (pend_b[0])
);

// File: tb/ipi_ctrl_test.sv
`timescale 1ns/1ps
module ipi_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  nw_addr = '0, app_addr = '0;
    logic        nw_wr = 1'b0, app_wr = 1'b0;
    logic [31:0] nw_wdata = '0, app_wdata = '0;
    logic [31:0] nw_rdata, app_rdata;
    logic        irq_nw, irq_app;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ipi_ctrl uut (
        .clk(clk), .rst(rst),
        .nw_addr(nw_addr), .nw_wr(nw_wr), .nw_wdata(nw_wdata), .nw_rdata(nw_rdata),
        .app_addr(app_addr), .app_wr(app_wr), .app_wdata(app_wdata), .app_rdata(app_rdata),
        .irq_nw(irq_nw), .irq_app(irq_app)
    );

    typedef struct packed {
        logic        port;   // 0 network port, 1 application port
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'h98, 32'h0000_00F0, 8'hA0, 32'h0000_00F0, 4'd4}, // R4 trigger
        '{1'b0, 8'h8C, 32'h0000_0030, 8'h84, 32'hFFFF_FFCF, 4'd3}, // R3 mask clear
        '{1'b0, 8'h88, 32'h0000_0000, 8'h9C, 32'h0000_0030, 4'd7}, // R7 masked view, R3 zero ignored
        '{1'b0, 8'h90, 32'h0000_0010, 8'hA0, 32'h0000_00E0, 4'd5}, // R5 status clear
        '{1'b0, 8'h94, 32'h0000_0020, 8'hA0, 32'h0000_00C0, 4'd5}, // R5 ack
        '{1'b1, 8'h98, 32'h0000_0000, 8'h98, 32'h0000_0000, 4'd4}, // R4 reads zero
        '{1'b1, 8'h88, 32'h0000_0010, 8'h84, 32'hFFFF_FFDF, 4'd3}, // R3 mask set
        '{1'b1, 8'hB8, 32'h8000_0001, 8'hC0, 32'h8000_0001, 4'd9}, // R9 second bank
        '{1'b0, 8'hA4, 32'h0000_0000, 8'hBC, 32'h8000_0001, 4'd2}, // R2 direct mask
        '{1'b0, 8'hB0, 32'hFFFF_FFFF, 8'hC0, 32'h0000_0000, 4'd5}, // R5 second bank
        '{1'b0, 8'h84, 32'h1234_5678, 8'h84, 32'h1234_5678, 4'd2}, // R2 readback
        '{1'b1, 8'h00, 32'hFFFF_FFFF, 8'hA0, 32'h0000_00C0, 4'd9}  // R9 unmapped ignored
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic port, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        nw_wr  = 1'b0;
        app_wr = 1'b0;
        if (port) begin app_addr = a; app_wdata = d; app_wr = 1'b1; end
        else      begin nw_addr  = a; nw_wdata  = d; nw_wr  = 1'b1; end
    endtask

    task automatic dual_write(input logic [7:0] an, input logic [31:0] dn,
                              input logic [7:0] aa, input logic [31:0] da);
        @(negedge clk);
        nw_addr = an;  nw_wdata = dn;  nw_wr = 1'b1;
        app_addr = aa; app_wdata = da; app_wr = 1'b1;
    endtask

    task automatic do_read(input logic port, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        nw_wr  = 1'b0;
        app_wr = 1'b0;
        if (port) app_addr = a; else nw_addr = a;
        #1;
        d = port ? app_rdata : nw_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
        nw_wr  = 1'b0;
        app_wr = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; nw_wr = 1'b0; app_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // R1 reset state
        do_read(1'b0, 8'h84, rd); check(rd, 32'hFFFF_FFFF, "R1", "network mask after reset");
        do_read(1'b1, 8'hA4, rd); check(rd, 32'hFFFF_FFFF, "R1", "application mask after reset");
        do_read(1'b0, 8'hA0, rd); check(rd, 32'h0, "R1", "raw status after reset");
        check({31'b0, irq_nw}, 32'h0, "R1", "irq_nw after reset");
        check({31'b0, irq_app}, 32'h0, "R1", "irq_app after reset");

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].port, VECS[i].waddr, VECS[i].wdata);
            do_read(VECS[i].port, VECS[i].raddr, rd);
            check(rd, VECS[i].exp, $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i));
        end

        // directed corner cases from a clean state
        do_reset();

        // R4 / R7: masked doorbell pends but stays invisible
        do_write(1'b1, 8'h98, 32'h10);
        do_read(1'b0, 8'hA0, rd); check(rd, 32'h10, "R4", "masked trigger pends");
        do_read(1'b0, 8'h9C, rd); check(rd, 32'h0, "R7", "masked status hides it");
        check({31'b0, irq_nw}, 32'h0, "R2", "masked bit raises no irq");

        // R8: one-cycle registered interrupt
        do_write(1'b1, 8'h8C, 32'h1);
        do_read(1'b0, 8'h84, rd); check(rd, 32'hFFFF_FFFE, "R3", "unmask bit0");
        do_write(1'b1, 8'h98, 32'h1);
        idle(); check({31'b0, irq_nw}, 32'h0, "R8", "irq not yet high");
        idle(); check({31'b0, irq_nw}, 32'h1, "R8", "irq high one edge later");

        // R6: clear on one port, trigger on the other, same bit
        dual_write(8'h90, 32'h11, 8'h98, 32'h1);
        do_read(1'b0, 8'hA0, rd); check(rd, 32'h1, "R6", "coincident trigger survives clear");

        // R5 / R8: ack drops the line one edge after pending clears
        do_write(1'b0, 8'h94, 32'h1);
        do_read(1'b0, 8'hA0, rd); check(rd, 32'h0, "R5", "ack retires bit");
        check({31'b0, irq_nw}, 32'h1, "R8", "irq still high");
        idle(); check({31'b0, irq_nw}, 32'h0, "R8", "irq low one edge later");

        // R3: set beats clear in the same cycle
        do_write(1'b0, 8'h8C, 32'h2);
        do_read(1'b0, 8'h84, rd); check(rd, 32'hFFFF_FFFC, "R3", "clear bit1");
        dual_write(8'h88, 32'h2, 8'h8C, 32'h2);
        do_read(1'b0, 8'h84, rd); check(rd, 32'hFFFF_FFFE, "R3", "coincident set wins");

        // R9: application bank drives its own line
        do_write(1'b1, 8'hAC, 32'h4);
        do_write(1'b0, 8'hB8, 32'h4);
        idle(); check({31'b0, irq_app}, 32'h0, "R9", "irq_app not yet high");
        idle(); check({31'b0, irq_app}, 32'h1, "R9", "irq_app high");
        check({31'b0, irq_nw}, 32'h0, "R9", "irq_nw unaffected");
        do_read(1'b1, 8'h00, rd); check(rd, 32'h0, "R9", "unmapped reads zero");
        do_read(1'b1, 8'hA8, rd); check(rd, 32'h0, "R9", "alias reads zero");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule